// File: doc/BRIEF.md
# Alarm Page Store Controller

This block holds a 16-byte page of alarm settings split into two 8-byte alarms: alarm 0 at addresses 0x0 to 0x7 and alarm 1 at 0x8 to 0xF. An upstream serial front end, which is outside this block, delivers write bursts. A burst opens with a start strobe that carries a page address. Data byte strobes follow, and a stop strobe closes the burst. Each accepted byte lands in a volatile working copy of the page. The address steps up after every byte and wraps inside the page.

When a burst closes, the block looks only at the address of the last byte written. Within either alarm, if that byte sat at offset 0 to 4, the whole working copy is transferred into the stored (nonvolatile) copy. The block then reports a one-cycle store pulse and holds a busy flag for a fixed number of cycles, which stands in for the cell programming time. Offsets 5, 6 and 7 never start a store by themselves. The day-of-week byte of either alarm can only reach storage if the burst runs on past the top of that alarm into a qualifying byte.

Reads of the working copy are combinational. A second read port shows the stored copy.

Top module: `alarm_page_commit`

## Requirements
- R1: After reset the working copy and the stored copy read as zero at all 16 addresses, and the store pulse, busy flag and error flag are low.
- R2: A byte accepted in an open burst is written to the working copy at the burst's current address, and rdData shows the working copy at rdAddr.
- R3: The burst address starts at startAddr, rises by one after each accepted byte, and wraps from 0xF to 0x0.
- R4: A stop closing a burst whose last written address has low three bits in 0..4 (0x0-0x4, 0x8-0xC) copies all 16 working bytes to the stored copy at that edge and raises nvCommit for exactly the next cycle.
- R5: A stop whose last written address is 0x5, 0x6, 0x7, 0xD, 0xE or 0xF produces no store pulse and leaves the stored copy unchanged, while the working copy keeps the new bytes.
- R6: A stop closing a burst in which no byte was written produces no store.
- R7: nvBusy is high for exactly BUSY_CYCLES cycles, starting in the cycle where nvCommit is high, and no further store can occur while it is high.
- R8: A data byte or start strobe that arrives while nvBusy is high is ignored, and it raises wrError for the single following cycle.
- R9: A start that arrives inside an open burst abandons that burst without a store, even if its last byte was at a qualifying address. Storage then waits for a qualifying stop.
- R10: A data byte presented with no burst open is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstStart | input | 1 | Opens a burst at startAddr |
| startAddr | input | 4 | First page address of the burst |
| wrValid | input | 1 | Data byte strobe |
| wrData | input | 8 | Data byte |
| burstStop | input | 1 | Closes the open burst |
| rdAddr | input | 4 | Working copy read address |
| rdData | output | 8 | Working copy byte at rdAddr |
| nvAddr | input | 4 | Stored copy read address |
| nvData | output | 8 | Stored copy byte at nvAddr |
| nvCommit | output | 1 | One-cycle store pulse |
| nvBusy | output | 1 | Store in progress |
| wrError | output | 1 | One-cycle flag for input rejected while busy |

## Verification
The hardest cases to reach from the ports are the ones where the decision depends on a wrapped address: a 16-byte burst that passes 0xF and ends on 0x0 or 0x8, and a short burst that carries the day-of-week byte over the alarm boundary. The stimulus drives full-page bursts that start at 0x1 and at 0x9, and a three-byte burst that starts at 0x6. Rejection while busy is reached by presenting a byte, and then a start, in the cycles right after a store pulse. An abandoned burst is produced by issuing a second start after a byte at a qualifying address, with no stop in between.

// File: rtl/alarm_page_pkg.sv
package alarm_page_pkg;
  // page geometry
  localparam int PAGE_AW  = 4;
  localparam int PAGE_DW  = 8;
  localparam int PAGE_DEPTH = 1 << PAGE_AW;
  // each alarm spans 2**ALARM_AW bytes; offsets up to TRIG_MAX start a store
  localparam int ALARM_AW = 3;
  localparam logic [ALARM_AW-1:0] TRIG_MAX = ALARM_AW'(4);

  typedef logic [PAGE_AW-1:0] pageAddr_t;
  typedef logic [PAGE_DW-1:0] pageByte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;    // write one byte into the working copy
    pageAddr_t addr;    // working copy address for load
    logic      commit;  // copy working page into stored page
  } pageStrobe_t;

  function automatic logic endsStore(input pageAddr_t lastAddr);
    return lastAddr[ALARM_AW-1:0] <= TRIG_MAX;
  endfunction
endpackage

// File: rtl/alarm_page_ctrl.sv
module alarm_page_ctrl
  import alarm_page_pkg::*;
#(
  parameter int BUSY_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        burstStart,
  input  pageAddr_t   startAddr,
  input  logic        wrValid,
  input  logic        burstStop,
  output pageStrobe_t strobe,
  output logic        nvCommit,
  output logic        nvBusy,
  output logic        wrError
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam pageAddr_t ADDR_ONE = PAGE_AW'(1);

  logic             inBurst;
  logic             wroteAny;
  pageAddr_t        curAddr;
  pageAddr_t        lastAddr;
  logic [CNT_W-1:0] busyCnt;
  logic             commitQ;
  logic             errQ;

  logic acceptStart;
  logic acceptByte;
  logic closeBurst;
  logic commitNow;
  logic busyHit;

  assign nvBusy = (busyCnt != '0);

  always_comb begin
    acceptStart = burstStart && !nvBusy;
    acceptByte  = wrValid && inBurst && !burstStart && !burstStop && !nvBusy;
    closeBurst  = burstStop && inBurst && !burstStart && !nvBusy;
    commitNow   = closeBurst && wroteAny && endsStore(lastAddr);
    busyHit     = nvBusy && (wrValid || burstStart);
    strobe.load   = acceptByte;
    strobe.addr   = curAddr;
    strobe.commit = commitNow;
  end

  // burst tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBurst  <= 1'b0;
      wroteAny <= 1'b0;
      curAddr  <= '0;
      lastAddr <= '0;
    end else if (acceptStart) begin
      inBurst  <= 1'b1;
      wroteAny <= 1'b0;
      curAddr  <= startAddr;
    end else if (acceptByte) begin
      wroteAny <= 1'b1;
      lastAddr <= curAddr;
      curAddr  <= curAddr + ADDR_ONE;
    end else if (closeBurst) begin
      inBurst  <= 1'b0;
    end
  end

  // store timing and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      commitQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      commitQ <= commitNow;
      errQ    <= busyHit;
      if (commitNow)
        busyCnt <= BUSY_LOAD;
      else if (nvBusy)
        busyCnt <= busyCnt - CNT_ONE;
    end
  end

  assign nvCommit = commitQ;
  assign wrError  = errQ;
endmodule

// File: rtl/alarm_page_dp.sv
module alarm_page_dp
  import alarm_page_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pageStrobe_t strobe,
  input  pageByte_t   wrData,
  input  pageAddr_t   rdAddr,
  output pageByte_t   rdData,
  input  pageAddr_t   nvAddr,
  output pageByte_t   nvData
);
  pageByte_t workPage [PAGE_DEPTH];
  pageByte_t storePage[PAGE_DEPTH];

  for (genvar g = 0; g < PAGE_DEPTH; g++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        workPage[g] <= '0;
      else if (strobe.load && strobe.addr == PAGE_AW'(g))
        workPage[g] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        storePage[g] <= '0;
      else if (strobe.commit)
        storePage[g] <= workPage[g];
    end
  end

  assign rdData = workPage[rdAddr];
  assign nvData = storePage[nvAddr];
endmodule

// File: rtl/alarm_page_commit.sv
module alarm_page_commit
  import alarm_page_pkg::*;
#(
  parameter int BUSY_CYCLES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstStart,
  input  logic [PAGE_AW-1:0]  startAddr,
  input  logic                wrValid,
  input  logic [PAGE_DW-1:0]  wrData,
  input  logic                burstStop,
  input  logic [PAGE_AW-1:0]  rdAddr,
  output logic [PAGE_DW-1:0]  rdData,
  input  logic [PAGE_AW-1:0]  nvAddr,
  output logic [PAGE_DW-1:0]  nvData,
  output logic                nvCommit,
  output logic                nvBusy,
  output logic                wrError
);
  pageStrobe_t strobe;

  alarm_page_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .burstStart (burstStart),
    .startAddr  (startAddr),
    .wrValid    (wrValid),
    .burstStop  (burstStop),
    .strobe     (strobe),
    .nvCommit   (nvCommit),
    .nvBusy     (nvBusy),
    .wrError    (wrError)
  );

  alarm_page_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .nvAddr (nvAddr),
    .nvData (nvData)
  );
endmodule

// File: rtl/alarm_page_chk.sv
module alarm_page_chk
  import alarm_page_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              burstStart,
  input logic              wrValid,
  input logic [PAGE_AW-1:0] nvAddr,
  input logic [PAGE_DW-1:0] nvData,
  input logic              nvCommit,
  input logic              nvBusy,
  input logic              wrError
);
  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |=> !nvCommit);

  p_commit_sets_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |-> nvBusy);

  p_no_commit_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    nvBusy |=> !nvCommit);

  p_busy_input_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (nvBusy && (wrValid || burstStart)) |=> wrError);

  p_error_needs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrError |-> $past(nvBusy));

  p_store_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!nvCommit && $stable(nvAddr)) |-> $stable(nvData));
endmodule

bind alarm_page_commit alarm_page_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .burstStart (burstStart),
  .wrValid    (wrValid),
  .nvAddr     (nvAddr),
  .nvData     (nvData),
  .nvCommit   (nvCommit),
  .nvBusy     (nvBusy),
  .wrError    (wrError)
);

// File: tb/sim_alarm_page_commit.sv
`timescale 1ns/1ps
module sim_alarm_page_commit;
  localparam int BUSY = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       burstStart = 1'b0;
  logic [3:0] startAddr = '0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       burstStop = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [3:0] nvAddr = '0;
  logic [7:0] nvData;
  logic       nvCommit, nvBusy, wrError;

  always #2 clk = ~clk;

  alarm_page_commit #(.BUSY_CYCLES(BUSY)) u0 (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] expWork [16];
  logic [7:0] expStore[16];
  bit         mIn = 0;
  bit         mWrote = 0;
  logic [3:0] mAddr = '0;
  logic [3:0] mLast = '0;
  int         expQ[$];   // expected store events: expected busy length

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [3:0] a);
    burstStart = 1'b1; startAddr = a;
    @(negedge clk);
    burstStart = 1'b0;
    mIn = 1; mWrote = 0; mAddr = a;
  endtask

  task automatic doByte(input logic [7:0] d);
    wrValid = 1'b1; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    if (mIn) begin
      expWork[mAddr] = d; mLast = mAddr; mAddr = mAddr + 4'd1; mWrote = 1;
    end
  endtask

  task automatic doStop();
    burstStop = 1'b1;
    if (mIn && mWrote && mLast[2:0] <= 3'd4) begin
      expQ.push_back(BUSY);
      for (int i = 0; i < 16; i++) expStore[i] = expWork[i];
    end
    mIn = 0;
    @(negedge clk);
    burstStop = 1'b0;
  endtask

  task automatic waitIdle();
    while (nvBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkPage(input string req);
    for (int i = 0; i < 16; i++) begin
      rdAddr = 4'(i); nvAddr = 4'(i);
      #0.5;
      check(rdData == expWork[i], {req, " working byte"}, rdData, expWork[i]);
      check(nvData == expStore[i], {req, " stored byte"}, nvData, expStore[i]);
    end
    @(negedge clk);
  endtask

  // monitor: pops expected store events, measures busy length
  bit measuring = 0;
  int busyLen = 0;
  int expLen = 0;
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (nvCommit) begin
        if (expQ.size() == 0)
          check(0, "R4/R5/R6/R9 unexpected store pulse", 1, 0);
        else begin
          expLen = expQ.pop_front();
          total++;
          measuring = 1; busyLen = 0;
        end
      end
      if (measuring) begin
        if (nvBusy) busyLen++;
        else begin
          measuring = 0;
          check(busyLen == expLen, "R7 busy length", busyLen, expLen);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin expWork[i] = '0; expStore[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!nvCommit && !nvBusy && !wrError, "R1 flags after reset",
          {nvCommit, nvBusy, wrError}, 0);
    checkPage("R1");

    // R4: day-of-week carried over the alarm boundary (0x6,0x7,0x8)
    doStart(4'h6); doByte(8'h16); doByte(8'h17); doByte(8'h18); doStop();
    #1 check(nvCommit == 1'b1, "R4 store pulse after 0x6..0x8", nvCommit, 1);
    @(negedge clk);
    waitIdle();
    checkPage("R4 boundary burst");

    // R5: burst ending at 0x5 keeps stored copy, R2 working copy updated
    doStart(4'h3); doByte(8'h33); doByte(8'h34); doByte(8'h35); doStop();
    #1 check(nvCommit == 1'b0, "R5 no store ending at 0x5", nvCommit, 0);
    @(negedge clk);
    checkPage("R5/R2");

    // R3/R4: full page from 0x9 ending at 0x8
    doStart(4'h9);
    for (int i = 0; i < 16; i++) doByte(8'hA0 + 8'(i));
    doStop();
    waitIdle();
    checkPage("R3/R4 wrap from 0x9");

    // R3/R4: full page from 0x1 ending at 0x0
    doStart(4'h1);
    for (int i = 0; i < 16; i++) doByte(8'h50 + 8'(i));
    doStop();
    waitIdle();
    checkPage("R3/R4 wrap from 0x1");

    // R5: single bytes at the top of each alarm
    doStart(4'h7); doByte(8'h77); doStop();
    doStart(4'hF); doByte(8'hFF); doStop();
    doStart(4'hE); doByte(8'hEE); doStop();
    checkPage("R5 tops and day bytes");

    // R4 then R8: single byte at 0xC stores; inputs during busy rejected
    doStart(4'hC); doByte(8'hCC); doStop();
    wrValid = 1'b1; wrData = 8'h99;
    @(negedge clk);
    wrValid = 1'b0;
    #1 check(wrError == 1'b1, "R8 error on byte while busy", wrError, 1);
    @(negedge clk);
    #1 check(wrError == 1'b0, "R8 error lasts one cycle", wrError, 0);
    @(negedge clk);
    burstStart = 1'b1; startAddr = 4'h2;
    @(negedge clk);
    burstStart = 1'b0;
    #1 check(wrError == 1'b1, "R8 error on start while busy", wrError, 1);
    @(negedge clk);
    waitIdle();
    // R8/R10: rejected start opened no burst, so this byte is ignored without error
    wrValid = 1'b1; wrData = 8'h42;
    @(negedge clk);
    wrValid = 1'b0;
    #1 check(wrError == 1'b0, "R10 no error on byte outside burst", wrError, 0);
    @(negedge clk);
    checkPage("R8/R10 after busy");

    // R9: abandoned burst ending at qualifying address, then non-qualifying stop
    doStart(4'h0); doByte(8'h01);
    doStart(4'h5); doByte(8'h05); doStop();
    #1 check(nvCommit == 1'b0, "R9 no store for abandoned burst", nvCommit, 0);
    @(negedge clk);
    checkPage("R9");

    // R6: empty burst
    doStart(4'h2); doStop();
    #1 check(nvCommit == 1'b0, "R6 no store for empty burst", nvCommit, 0);
    @(negedge clk);
    // R9 follow-up: a qualifying stop stores the earlier shadow bytes
    doStart(4'h4); doByte(8'h44); doStop();
    waitIdle();
    checkPage("R6/R9 later store");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R4 every expected store seen", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule